// File: doc/BRIEF.md
# Shared-Buffer Multi-Queue Cell Manager

This block keeps the bookkeeping for a shared on-chip cell buffer of 256 slots. The slots are threaded into linked lists: one free list, and one logical queue per combination of destination port, priority level and merge lane (the flow group that a cell belongs to on its output). Ports 0 to 15 are the regular outputs, port 16 is the management port and port 17 carries the multicast queues. The slot number handed out at enqueue is the cell's handle; payload storage lives outside the block.

On each cycle the block accepts at most one enqueue and one dequeue. A dequeue names a port and presents a credit-eligible bit per merge lane of that port, supplied by external credit counters. The block answers in the same cycle with the chosen slot. Priority 0 is served first. Within a priority the eligible lanes are served round-robin. A lane without credit is passed over and does not hold back the other lanes. A dequeued slot joins the free list at once.

Top module: `cm_shared_queue_mgr`

## Requirements
- R1: After reset every queue is empty, `enq_full` is 0, `deq_valid` is 0, and the free list hands out slots in ascending order 0, 1, 2, ... through `enq_slot`.
- R2: An enqueue is accepted (`enq_accept`=1) only when `enq_valid` is 1, a free slot exists, `enq_port` is below 18 and `enq_pri` is below 3. `enq_full` is 1 exactly when no slot is free. A refused enqueue leaves the queues and the free list unchanged.
- R3: Cells of one queue (same port, priority and lane) leave in the order they arrived.
- R4: A dequeue serves the lowest-numbered priority level (0 highest) that holds an eligible cell.
- R5: Within a priority level of a port, the search starts at the lane after the one served last, wrapping from 3 to 0. After reset the search starts at lane 0.
- R6: A lane whose `deq_credit` bit (bit n for lane n) is 0 is never served. Eligible lanes on the same port are still served. `deq_valid` is 0 when no lane is eligible.
- R7: A dequeued slot is appended to the tail of the free list in the same cycle. If the free list was empty, that slot is offered on `enq_slot` in the next cycle, and an enqueue in the dequeue cycle itself is refused.
- R8: On the multicast port (17) the lane field of an enqueue is ignored and the cell is kept on lane 0. It is served under credit bit 0.
- R9: `deq_valid`, `deq_slot`, `deq_pri` and `deq_lane` are combinational in the request cycle. A dequeue takes effect only when `deq_req` is 1. Without `deq_req`, `deq_valid` is 0 and no queue changes.
- R10: One enqueue and one dequeue may occur in the same cycle, including on the same queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on the clock |
| enq_valid | input | 1 | Enqueue request |
| enq_port | input | 5 | Destination port: 0-15 outputs, 16 management, 17 multicast |
| enq_pri | input | 2 | Priority level, 0 highest |
| enq_lane | input | 2 | Merge lane (flow group) on the destination port |
| enq_accept | output | 1 | Enqueue taken this cycle |
| enq_full | output | 1 | No free slot |
| enq_slot | output | 8 | Slot that an accepted enqueue receives |
| deq_req | input | 1 | Dequeue request |
| deq_port | input | 5 | Port to serve |
| deq_credit | input | 4 | Credit-eligible bit per lane of the served port |
| deq_valid | output | 1 | A cell leaves this cycle |
| deq_slot | output | 8 | Slot of the departing cell |
| deq_pri | output | 2 | Priority of the departing cell |
| deq_lane | output | 2 | Lane of the departing cell |

## Verification
Every output of the block is combinational from its registered queue state and the present inputs. A grant, a refusal or a slot number is therefore due in the cycle of the request. The effect of an enqueue or dequeue on the queues, the free list and the round-robin pointers first shows in the following cycle. The bench drives inputs on the falling edge and samples a quarter period later, before the rising edge that commits them. Each vector thus checks the immediate answer, and the next vector checks the committed state. The full-buffer case is checked one cycle after the freeing dequeue, where the recycled slot must appear.

// File: rtl/cm_pkg.sv
package cm_pkg;
    localparam int CM_SLOTS = 256;
    localparam int CM_OUTS  = 16;
    localparam int CM_PRIS  = 3;
    localparam int CM_LANES = 4;
endpackage

// File: rtl/cm_link_ram.sv
module cm_link_ram #(
    parameter int SLOTS = 256,
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PTR_W-1:0] ra_addr,
    output logic [PTR_W-1:0] ra_data,
    input  logic [PTR_W-1:0] rb_addr,
    output logic [PTR_W-1:0] rb_data,
    input  logic             wa_en,
    input  logic [PTR_W-1:0] wa_addr,
    input  logic [PTR_W-1:0] wa_data,
    input  logic             wb_en,
    input  logic [PTR_W-1:0] wb_addr,
    input  logic [PTR_W-1:0] wb_data
);
    logic [PTR_W-1:0] link_q [SLOTS];

    assign ra_data = link_q[ra_addr];
    assign rb_data = link_q[rb_addr];

    // reset threads every slot into one chain 0 -> 1 -> ... -> SLOTS-1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) begin
                link_q[i] <= PTR_W'((i + 1) % SLOTS);
            end
        end else begin
            if (wa_en) link_q[wa_addr] <= wa_data;
            if (wb_en) link_q[wb_addr] <= wb_data;
        end
    end

    // R10: queue append and free-list append never hit the same link
    a_r10_write_ports_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
        (wa_en && wb_en) |-> (wa_addr != wb_addr));
endmodule

// File: rtl/cm_rr_pick.sv
module cm_rr_pick #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic [N-1:0] req_i,
    input  logic [W-1:0] last_i,
    output logic [W-1:0] gnt_o,
    output logic         any_o
);
    always_comb begin
        any_o = 1'b0;
        gnt_o = '0;
        for (int k = 1; k <= N; k++) begin
            int idx;
            idx = (int'(last_i) + k) % N;
            if (!any_o && req_i[idx]) begin
                any_o = 1'b1;
                gnt_o = W'(idx);
            end
        end
    end
endmodule

// File: rtl/cm_shared_queue_mgr.sv
module cm_shared_queue_mgr
    import cm_pkg::*;
#(
    parameter int SLOTS = CM_SLOTS,
    parameter int OUTS  = CM_OUTS,
    parameter int PRIS  = CM_PRIS,
    parameter int LANES = CM_LANES
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          enq_valid,
    input  logic [$clog2(OUTS+2)-1:0]     enq_port,
    input  logic [$clog2(PRIS)-1:0]       enq_pri,
    input  logic [$clog2(LANES)-1:0]      enq_lane,
    output logic                          enq_accept,
    output logic                          enq_full,
    output logic [$clog2(SLOTS)-1:0]      enq_slot,
    input  logic                          deq_req,
    input  logic [$clog2(OUTS+2)-1:0]     deq_port,
    input  logic [LANES-1:0]              deq_credit,
    output logic                          deq_valid,
    output logic [$clog2(SLOTS)-1:0]      deq_slot,
    output logic [$clog2(PRIS)-1:0]       deq_pri,
    output logic [$clog2(LANES)-1:0]      deq_lane
);
    localparam int PTR_W   = $clog2(SLOTS);
    localparam int CNT_W   = $clog2(SLOTS + 1);
    localparam int PORTS   = OUTS + 2;
    localparam int PRI_W   = $clog2(PRIS);
    localparam int LANE_W  = $clog2(LANES);
    localparam int NQ      = PORTS * PRIS * LANES;
    localparam int NRR     = PORTS * PRIS;
    localparam int MC_PORT = OUTS + 1;

    typedef struct packed {
        logic [NQ-1:0][PTR_W-1:0]   head;
        logic [NQ-1:0][PTR_W-1:0]   tail;
        logic [NQ-1:0]              busy;
        logic [NRR-1:0][LANE_W-1:0] rr;
        logic [PTR_W-1:0]           fl_head;
        logic [PTR_W-1:0]           fl_tail;
        logic [CNT_W-1:0]           fl_cnt;
    } mgr_state_t;

    function automatic int qidx(int port, int pri, int lane);
        return (port * PRIS + pri) * LANES + lane;
    endfunction

    mgr_state_t st_d, st_q;

    logic             enq_legal;
    logic [LANE_W-1:0] enq_lane_eff;
    int               eq_d;
    logic             dport_ok;
    int               dport_i;
    logic [PRIS-1:0]  pri_any;
    logic [LANE_W-1:0] pri_gnt [PRIS];
    logic             sel_found;
    int               sel_p;
    logic [LANE_W-1:0] sel_l;
    int               dq_d;
    logic             deq_fire;
    logic [PTR_W-1:0] fl_next;
    logic [PTR_W-1:0] dq_next;
    logic             wa_en, wb_en;
    logic [PTR_W-1:0] wa_addr, wa_data, wb_addr, wb_data;

    // ---------------- enqueue decode ----------------
    always_comb begin
        enq_legal    = (int'(enq_port) < PORTS) && (int'(enq_pri) < PRIS);
        enq_lane_eff = (int'(enq_port) == MC_PORT) ? '0 : enq_lane;
        eq_d         = enq_legal ? qidx(int'(enq_port), int'(enq_pri), int'(enq_lane_eff)) : 0;
        enq_full     = (st_q.fl_cnt == '0);
        enq_accept   = enq_valid && enq_legal && !enq_full;
        enq_slot     = st_q.fl_head;
    end

    // ---------------- dequeue selection ----------------
    always_comb begin
        dport_ok = int'(deq_port) < PORTS;
        dport_i  = dport_ok ? int'(deq_port) : 0;
    end

    for (genvar p = 0; p < PRIS; p++) begin : g_pri
        logic [LANES-1:0]  lane_req;
        logic [LANE_W-1:0] lane_gnt;
        logic              lane_any;
        always_comb begin
            for (int l = 0; l < LANES; l++) begin
                lane_req[l] = dport_ok && st_q.busy[qidx(dport_i, p, l)] && deq_credit[l];
            end
        end
        cm_rr_pick #(.N(LANES), .W(LANE_W)) u_pick (
            .req_i  (lane_req),
            .last_i (st_q.rr[dport_i * PRIS + p]),
            .gnt_o  (lane_gnt),
            .any_o  (lane_any)
        );
        assign pri_any[p] = lane_any;
        assign pri_gnt[p] = lane_gnt;
    end

    always_comb begin
        sel_found = 1'b0;
        sel_p     = 0;
        sel_l     = '0;
        for (int p = PRIS - 1; p >= 0; p--) begin
            if (pri_any[p]) begin
                sel_found = 1'b1;
                sel_p     = p;
                sel_l     = pri_gnt[p];
            end
        end
        dq_d      = qidx(dport_i, sel_p, int'(sel_l));
        deq_fire  = deq_req && sel_found;
        deq_valid = deq_fire;
        deq_slot  = st_q.head[dq_d];
        deq_pri   = PRI_W'(sel_p);
        deq_lane  = sel_l;
    end

    cm_link_ram #(.SLOTS(SLOTS), .PTR_W(PTR_W)) u_links (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_addr (st_q.fl_head),
        .ra_data (fl_next),
        .rb_addr (deq_slot),
        .rb_data (dq_next),
        .wa_en   (wa_en),
        .wa_addr (wa_addr),
        .wa_data (wa_data),
        .wb_en   (wb_en),
        .wb_addr (wb_addr),
        .wb_data (wb_data)
    );

    // ---------------- next state ----------------
    always_comb begin
        st_d    = st_q;
        wa_en   = 1'b0;
        wa_addr = '0;
        wa_data = '0;
        wb_en   = 1'b0;
        wb_addr = '0;
        wb_data = '0;

        if (deq_fire) begin
            if (st_q.head[dq_d] == st_q.tail[dq_d]) begin
                st_d.busy[dq_d] = 1'b0;
            end else begin
                st_d.head[dq_d] = dq_next;
            end
            st_d.rr[dport_i * PRIS + sel_p] = sel_l;
            if (st_q.fl_cnt != '0) begin
                wb_en   = 1'b1;
                wb_addr = st_q.fl_tail;
                wb_data = deq_slot;
            end else begin
                st_d.fl_head = deq_slot;
            end
            st_d.fl_tail = deq_slot;
        end

        if (enq_accept) begin
            if (st_q.fl_cnt == CNT_W'(1)) begin
                st_d.fl_head = deq_fire ? deq_slot : st_q.fl_head;
            end else begin
                st_d.fl_head = fl_next;
            end
            if (st_d.busy[eq_d]) begin
                wa_en   = 1'b1;
                wa_addr = st_q.tail[eq_d];
                wa_data = st_q.fl_head;
            end else begin
                st_d.head[eq_d] = st_q.fl_head;
                st_d.busy[eq_d] = 1'b1;
            end
            st_d.tail[eq_d] = st_q.fl_head;
        end

        st_d.fl_cnt = st_q.fl_cnt + CNT_W'(deq_fire) - CNT_W'(enq_accept);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.head    <= '0;
            st_q.tail    <= '0;
            st_q.busy    <= '0;
            for (int i = 0; i < NRR; i++) begin
                st_q.rr[i] <= LANE_W'(LANES - 1);
            end
            st_q.fl_head <= '0;
            st_q.fl_tail <= PTR_W'(SLOTS - 1);
            st_q.fl_cnt  <= CNT_W'(SLOTS);
        end else begin
            st_q <= st_d;
        end
    end

    // ---------------- assertions ----------------
    logic [CNT_W-1:0] occ_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= '0;
        end else begin
            occ_q <= occ_q + CNT_W'(enq_accept) - CNT_W'(deq_valid);
        end
    end

    // R2: slots are never created or lost
    a_r2_slots_conserved: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, occ_q} + {1'b0, st_q.fl_cnt}) == (CNT_W+1)'(SLOTS));

    // R2: a refused enqueue on a full buffer with no departure leaves it full
    a_r2_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && enq_full && !deq_req) |=> enq_full);

    // R6: a served lane always carries credit
    a_r6_grant_has_credit: assert property (@(posedge clk) disable iff (!rst_n)
        deq_valid |-> deq_credit[deq_lane]);

    // R7: a slot freed while full is offered next cycle
    a_r7_freed_slot_offered: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_valid && enq_full) |=> (!enq_full && enq_slot == $past(deq_slot)));

    // R8: multicast cells always leave from lane 0
    a_r8_mc_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_valid && int'(deq_port) == MC_PORT) |-> (deq_lane == '0));

    // R9: no request, no departure
    a_r9_no_req_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
        !deq_req |-> !deq_valid);
endmodule

// File: tb/cm_shared_queue_mgr_bench.sv
module cm_shared_queue_mgr_bench;
    localparam int CLK_PER = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       enq_valid;
    logic [4:0] enq_port;
    logic [1:0] enq_pri;
    logic [1:0] enq_lane;
    logic       enq_accept;
    logic       enq_full;
    logic [7:0] enq_slot;
    logic       deq_req;
    logic [4:0] deq_port;
    logic [3:0] deq_credit;
    logic       deq_valid;
    logic [7:0] deq_slot;
    logic [1:0] deq_pri;
    logic [1:0] deq_lane;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PER/2) clk = ~clk;

    cm_shared_queue_mgr u_cm_shared_queue_mgr (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_port(enq_port), .enq_pri(enq_pri), .enq_lane(enq_lane),
        .enq_accept(enq_accept), .enq_full(enq_full), .enq_slot(enq_slot),
        .deq_req(deq_req), .deq_port(deq_port), .deq_credit(deq_credit),
        .deq_valid(deq_valid), .deq_slot(deq_slot), .deq_pri(deq_pri), .deq_lane(deq_lane)
    );

    typedef struct packed {
        logic       ev;
        logic [4:0] ep;
        logic [1:0] epr;
        logic [1:0] el;
        logic       dr;
        logic [4:0] dp;
        logic [3:0] cr;
        logic       xa;
        logic [7:0] xs;
        logic       xv;
        logic [7:0] xd;
        logic [1:0] xp;
        logic [1:0] xl;
        logic [7:0] tag;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VEC [NV] = '{
        // ev  ep     epr   el    dr  dp     cr      xa  xs      xv  xd      xp    xl    tag
        '{1'b1,5'd3, 2'd1,2'd0,1'b0,5'd0, 4'hF,  1'b1,8'd0, 1'b0,8'd0, 2'd0,2'd0,8'd3},  // R3 fill lane0
        '{1'b1,5'd3, 2'd1,2'd1,1'b0,5'd0, 4'hF,  1'b1,8'd1, 1'b0,8'd0, 2'd0,2'd0,8'd5},
        '{1'b1,5'd3, 2'd1,2'd0,1'b0,5'd0, 4'hF,  1'b1,8'd2, 1'b0,8'd0, 2'd0,2'd0,8'd3},
        '{1'b1,5'd3, 2'd0,2'd2,1'b0,5'd0, 4'hF,  1'b1,8'd3, 1'b0,8'd0, 2'd0,2'd0,8'd4},
        '{1'b0,5'd0, 2'd0,2'd0,1'b1,5'd3, 4'hF,  1'b0,8'd4, 1'b1,8'd3, 2'd0,2'd2,8'd4},  // R4 pri0 first
        '{1'b0,5'd0, 2'd0,2'd0,1'b1,5'd3, 4'hF,  1'b0,8'd4, 1'b1,8'd0, 2'd1,2'd0,8'd5},  // R5 lane0 first
        '{1'b0,5'd0, 2'd0,2'd0,1'b1,5'd3, 4'hF,  1'b0,8'd4, 1'b1,8'd1, 2'd1,2'd1,8'd5},
        '{1'b0,5'd0, 2'd0,2'd0,1'b1,5'd3, 4'hF,  1'b0,8'd4, 1'b1,8'd2, 2'd1,2'd0,8'd3},
        '{1'b0,5'd0, 2'd0,2'd0,1'b1,5'd3, 4'hF,  1'b0,8'd4, 1'b0,8'd0, 2'd0,2'd0,8'd9},
        '{1'b1,5'd5, 2'd2,2'd1,1'b0,5'd0, 4'hF,  1'b1,8'd4, 1'b0,8'd0, 2'd0,2'd0,8'd6},
        '{1'b1,5'd5, 2'd2,2'd2,1'b0,5'd0, 4'hF,  1'b1,8'd5, 1'b0,8'd0, 2'd0,2'd0,8'd6},
        '{1'b0,5'd0, 2'd0,2'd0,1'b1,5'd5, 4'hD,  1'b0,8'd6, 1'b1,8'd5, 2'd2,2'd2,8'd6},  // R6 skip lane1
        '{1'b0,5'd0, 2'd0,2'd0,1'b1,5'd5, 4'hD,  1'b0,8'd6, 1'b0,8'd0, 2'd0,2'd0,8'd6},
        '{1'b0,5'd0, 2'd0,2'd0,1'b1,5'd5, 4'hF,  1'b0,8'd6, 1'b1,8'd4, 2'd2,2'd1,8'd6},
        '{1'b1,5'd17,2'd0,2'd3,1'b0,5'd0, 4'hF,  1'b1,8'd6, 1'b0,8'd0, 2'd0,2'd0,8'd8},  // R8 multicast
        '{1'b0,5'd0, 2'd0,2'd0,1'b1,5'd17,4'h1,  1'b0,8'd7, 1'b1,8'd6, 2'd0,2'd0,8'd8},
        '{1'b1,5'd7, 2'd0,2'd0,1'b0,5'd0, 4'hF,  1'b1,8'd7, 1'b0,8'd0, 2'd0,2'd0,8'd10}, // R10
        '{1'b1,5'd7, 2'd0,2'd0,1'b1,5'd7, 4'hF,  1'b1,8'd8, 1'b1,8'd7, 2'd0,2'd0,8'd10},
        '{1'b0,5'd0, 2'd0,2'd0,1'b1,5'd7, 4'hF,  1'b0,8'd9, 1'b1,8'd8, 2'd0,2'd0,8'd10},
        '{1'b0,5'd0, 2'd0,2'd0,1'b1,5'd7, 4'hF,  1'b0,8'd9, 1'b0,8'd0, 2'd0,2'd0,8'd9},
        '{1'b1,5'd2, 2'd0,2'd0,1'b0,5'd0, 4'hF,  1'b1,8'd9, 1'b0,8'd0, 2'd0,2'd0,8'd9},  // R9
        '{1'b0,5'd0, 2'd0,2'd0,1'b0,5'd2, 4'hF,  1'b0,8'd10,1'b0,8'd0, 2'd0,2'd0,8'd9},
        '{1'b0,5'd0, 2'd0,2'd0,1'b1,5'd2, 4'hF,  1'b0,8'd10,1'b1,8'd9, 2'd0,2'd0,8'd9},
        '{1'b1,5'd20,2'd0,2'd0,1'b0,5'd0, 4'hF,  1'b0,8'd10,1'b0,8'd0, 2'd0,2'd0,8'd2},  // R2 bad port
        '{1'b1,5'd2, 2'd3,2'd0,1'b0,5'd0, 4'hF,  1'b0,8'd10,1'b0,8'd0, 2'd0,2'd0,8'd2},  // R2 bad pri
        '{1'b1,5'd2, 2'd0,2'd0,1'b0,5'd0, 4'hF,  1'b1,8'd10,1'b0,8'd0, 2'd0,2'd0,8'd2},
        '{1'b0,5'd0, 2'd0,2'd0,1'b1,5'd2, 4'hF,  1'b0,8'd11,1'b1,8'd10,2'd0,2'd0,8'd3}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle();
        enq_valid = 1'b0; enq_port = '0; enq_pri = '0; enq_lane = '0;
        deq_req = 1'b0; deq_port = '0; deq_credit = 4'hF;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        idle();
        do_reset();

        // R1: reset state
        deq_req = 1'b1; deq_port = 5'd3;
        #(CLK_PER/4);
        check("R1", "enq_full", int'(enq_full), 0);
        check("R1", "enq_slot", int'(enq_slot), 0);
        check("R1", "deq_valid", int'(deq_valid), 0);

        // table walk: one vector per cycle
        for (int v = 0; v < NV; v++) begin
            string rq;
            @(negedge clk);
            rq = $sformatf("R%0d", VEC[v].tag);
            enq_valid = VEC[v].ev; enq_port = VEC[v].ep; enq_pri = VEC[v].epr; enq_lane = VEC[v].el;
            deq_req = VEC[v].dr; deq_port = VEC[v].dp; deq_credit = VEC[v].cr;
            #(CLK_PER/4);
            check(rq, $sformatf("v%0d enq_accept", v), int'(enq_accept), int'(VEC[v].xa));
            check(rq, $sformatf("v%0d enq_slot", v), int'(enq_slot), int'(VEC[v].xs));
            check(rq, $sformatf("v%0d deq_valid", v), int'(deq_valid), int'(VEC[v].xv));
            if (VEC[v].xv) begin
                check(rq, $sformatf("v%0d deq_slot", v), int'(deq_slot), int'(VEC[v].xd));
                check(rq, $sformatf("v%0d deq_pri", v), int'(deq_pri), int'(VEC[v].xp));
                check(rq, $sformatf("v%0d deq_lane", v), int'(deq_lane), int'(VEC[v].xl));
            end
        end

        // R1 / R2: fill the whole buffer from a fresh reset
        do_reset();
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            idle();
            enq_valid = 1'b1; enq_port = 5'd0;
            #(CLK_PER/4);
            check("R1", "fill enq_slot", int'(enq_slot), i);
            check("R2", "fill enq_accept", int'(enq_accept), 1);
        end
        @(negedge clk);
        idle();
        enq_valid = 1'b1; enq_port = 5'd0;
        #(CLK_PER/4);
        check("R2", "full flag", int'(enq_full), 1);
        check("R2", "refused when full", int'(enq_accept), 0);

        // R7: dequeue on a full buffer, enqueue in the same cycle refused
        @(negedge clk);
        enq_valid = 1'b1; enq_port = 5'd0;
        deq_req = 1'b1; deq_port = 5'd0; deq_credit = 4'hF;
        #(CLK_PER/4);
        check("R3", "first out", int'(deq_slot), 0);
        check("R7", "enq during last-free deq", int'(enq_accept), 0);

        @(negedge clk);
        idle();
        enq_valid = 1'b1; enq_port = 5'd0;
        #(CLK_PER/4);
        check("R7", "not full after free", int'(enq_full), 0);
        check("R7", "recycled slot", int'(enq_slot), 0);
        check("R7", "recycled accept", int'(enq_accept), 1);

        @(negedge clk);
        idle();
        #(CLK_PER/4);
        check("R2", "full again", int'(enq_full), 1);

        // R3: drain in arrival order 1..255 then 0
        for (int i = 1; i <= 256; i++) begin
            @(negedge clk);
            idle();
            deq_req = 1'b1; deq_port = 5'd0;
            #(CLK_PER/4);
            check("R3", "drain valid", int'(deq_valid), 1);
            check("R3", "drain order", int'(deq_slot), i % 256);
        end
        @(negedge clk);
        idle();
        deq_req = 1'b1; deq_port = 5'd0;
        #(CLK_PER/4);
        check("R6", "empty after drain", int'(deq_valid), 0);
        check("R2", "free after drain", int'(enq_full), 0);

        @(negedge clk);
        idle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule